// File: doc/BRIEF.md
# Link Request Handler

This block sits on the physical-layer side of a backplane serial bus and answers the bus requests sent by the link layer. Each request arrives on a single wire, one bit per clock. It is decoded into one of three kinds: immediate, fair or priority. The block keeps at most one asynchronous (fair or priority) request waiting.

A waiting request is served only when a suitable bus gap is seen. At that gap the block first sends a status indication to the link and then arbitrates. A won arbitration is answered with a grant. An immediate request, such as the one the link makes to send an acknowledge, is served at once. It cancels any waiting asynchronous request. Its next answer is always a grant or a deny, never a status.

The arbitration step itself is abstracted. The block raises `arb_req`, and the environment answers with a one-cycle `arb_done` together with `arb_won`.

Top module: `lreq_handler`

## Requirements
- R1: While `rst_n` is low and after its release, `ind_valid` and `arb_req` are low and no request is waiting.
- R2: A request is framed on `lreq_in` as follows. The line idles low. A start bit of 1 comes first. It is followed by 3 type bits and then 3 data bits, each field MSB first, one bit per clock. The decoded request takes effect in the cycle after its last data bit.
- R3: The type codes are 3'b001 immediate, 3'b010 fair and 3'b011 priority. A request with any other type code has no effect on the outputs or on the waiting request.
- R4: A waiting fair request starts service only on a cycle with `fair_gap` high; `arb_gap` alone does not start it. Service starts with a one-cycle status on the next cycle (`ind_code` 2'b01, `ind_type` and `ind_data` of the request). From that same cycle `arb_req` is high.
- R5: A waiting priority request starts service on a cycle with either `fair_gap` or `arb_gap` high, with the same status-then-arbitrate sequence.
- R6: During asynchronous arbitration, `arb_done` with `arb_won` high produces a grant (`ind_code` 2'b10) carrying the waiting request's type and data. It also clears the waiting request and drops `arb_req`.
- R7: A lost asynchronous arbitration produces no indication and drops `arb_req`. The request stays waiting for the next qualifying gap.
- R8: An immediate request raises `arb_req` in the cycle after it is decoded. The following `arb_done` returns a grant when won, or a deny (`ind_code` 2'b11) when lost. Either answer carries type 3'b001 and the request's data.
- R9: An immediate request clears any waiting fair or priority request. After an immediate request, no status is sent before its grant or deny.
- R10: An immediate request decoded during asynchronous arbitration takes that arbitration over. An `arb_done` in the same cycle is discarded, and the next `arb_done` is answered as in R8.
- R11: A fair or priority request decoded while one is waiting replaces it, both type and data.
- R12: Every indication is a single-cycle pulse of `ind_valid`, and `ind_code` is never 2'b00 while `ind_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lreq_in | input | 1 | Serial request line from the link |
| fair_gap | input | 1 | Fair gap seen on the bus (one cycle) |
| arb_gap | input | 1 | Arbitration gap seen on the bus (one cycle) |
| arb_done | input | 1 | Arbitration outcome available (one cycle) |
| arb_won | input | 1 | Outcome qualifier: 1 won, 0 lost |
| arb_req | output | 1 | Block is arbitrating for the bus |
| ind_valid | output | 1 | Indication to the link is valid |
| ind_code | output | 2 | 01 status, 10 grant, 11 deny |
| ind_type | output | 3 | Type of the request the indication answers |
| ind_data | output | 3 | Data of the request the indication answers |

## Verification
The assertions check several rules on every cycle:
- no status while an immediate request is unanswered;
- a status always coincides with an active arbitration;
- a grant or deny always follows a cycle of arbitration;
- a deny only ever answers an immediate request;
- a decoded immediate request leaves nothing waiting.

Some behaviours need a cycle-accurate reference fed by the bench's own stimulus:
- correct serial framing;
- which gap releases which kind of request;
- retry after a lost arbitration;
- replacement of a waiting request;
- ignoring reserved codes;
- the exact data carried by each answer.

// File: rtl/lreq_pkg.sv
// Shared widths, request type codes, indication codes and sequencer states
// for the link request handler.
package lreq_pkg;

    parameter int TYPE_W = 3;

    localparam logic [TYPE_W-1:0] RT_IMM  = TYPE_W'(1);
    localparam logic [TYPE_W-1:0] RT_FAIR = TYPE_W'(2);
    localparam logic [TYPE_W-1:0] RT_PRI  = TYPE_W'(3);

    typedef enum logic [1:0] {
        IND_NONE   = 2'b00,
        IND_STATUS = 2'b01,
        IND_GRANT  = 2'b10,
        IND_DENY   = 2'b11
    } ind_code_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_IMM   = 2'b01,
        SQ_ASYNC = 2'b10
    } seq_state_t;

    // True for the two request kinds that wait for a bus gap.
    function automatic logic is_async(input logic [TYPE_W-1:0] t);
        return (t == RT_FAIR) || (t == RT_PRI);
    endfunction

endpackage

// File: rtl/lreq_deser.sv
// Serial request deserializer.
// Waits for a start bit on an idle-low line, then shifts TYPE_W + DATA_W
// bits MSB first. It emits the decoded word as a one-cycle pulse in the
// cycle after the last bit.
// Assumes the line returns low (or starts the next frame) after a frame.
module lreq_deser #(
    parameter int TYPE_W = 3,
    parameter int DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic              word_valid,
    output logic [TYPE_W-1:0] word_type,
    output logic [DATA_W-1:0] word_data
);

    localparam int FRAME_W = TYPE_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic               busy;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] next_word;

    assign next_word = {shreg[FRAME_W-2:0], ser_in};

    // Frame detection, bit shifting and word hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            word_valid <= 1'b0;
            word_type  <= '0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (busy) begin
                shreg <= next_word;
                if (bit_cnt == LAST) begin
                    busy       <= 1'b0;
                    bit_cnt    <= '0;
                    word_valid <= 1'b1;
                    word_type  <= next_word[FRAME_W-1:DATA_W];
                    word_data  <= next_word[DATA_W-1:0];
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (ser_in) begin
                busy    <= 1'b1;
                bit_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/lreq_slot.sv
// Single pending-request slot for fair and priority requests.
// A new async request overwrites the slot. An immediate request empties it.
// A served request empties it unless a new async request loads in the same
// cycle. Reserved type codes are ignored.
module lreq_slot
    import lreq_pkg::*;
#(
    parameter int DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [TYPE_W-1:0] word_type,
    input  logic [DATA_W-1:0] word_data,
    input  logic              serve,
    output logic              pend_valid,
    output logic [TYPE_W-1:0] pend_type,
    output logic [DATA_W-1:0] pend_data
);

    logic take_imm;
    logic take_async;

    assign take_imm   = word_valid && (word_type == RT_IMM);
    assign take_async = word_valid && is_async(word_type);

    // Slot update: cancel, replace or retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_type  <= '0;
            pend_data  <= '0;
        end else if (take_imm) begin
            pend_valid <= 1'b0;
        end else if (take_async) begin
            pend_valid <= 1'b1;
            pend_type  <= word_type;
            pend_data  <= word_data;
        end else if (serve) begin
            pend_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/lreq_seq.sv
// Service sequencer.
// It starts immediate requests at once and asynchronous requests on a
// qualifying gap, drives the arbitration request, and forms status, grant
// and deny indications.
// Assumes arb_done is a one-cycle pulse; pulses seen while idle are ignored.
module lreq_seq
    import lreq_pkg::*;
#(
    parameter int DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [TYPE_W-1:0] word_type,
    input  logic [DATA_W-1:0] word_data,
    input  logic              pend_valid,
    input  logic [TYPE_W-1:0] pend_type,
    input  logic [DATA_W-1:0] pend_data,
    input  logic              fair_gap,
    input  logic              arb_gap,
    input  logic              arb_done,
    input  logic              arb_won,
    output logic              serve,
    output logic              arb_req,
    output logic              ind_valid,
    output logic [1:0]        ind_code,
    output logic [TYPE_W-1:0] ind_type,
    output logic [DATA_W-1:0] ind_data
);

    seq_state_t        state;
    logic [DATA_W-1:0] imm_data;
    logic              new_imm;
    logic              gap_ok;

    assign new_imm = word_valid && (word_type == RT_IMM);
    // A priority request may also use the shorter arbitration gap.
    assign gap_ok  = fair_gap || ((pend_type == RT_PRI) && arb_gap);
    assign arb_req = (state != SQ_IDLE);
    assign serve   = (state == SQ_ASYNC) && arb_done && arb_won && !new_imm;

    // State, immediate data capture and indication register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            imm_data  <= '0;
            ind_valid <= 1'b0;
            ind_code  <= IND_NONE;
            ind_type  <= '0;
            ind_data  <= '0;
        end else begin
            ind_valid <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (new_imm) begin
                        state    <= SQ_IMM;
                        imm_data <= word_data;
                    end else if (pend_valid && gap_ok) begin
                        state     <= SQ_ASYNC;
                        ind_valid <= 1'b1;
                        ind_code  <= IND_STATUS;
                        ind_type  <= pend_type;
                        ind_data  <= pend_data;
                    end
                end
                SQ_IMM: begin
                    if (new_imm) begin
                        imm_data <= word_data;
                    end
                    if (arb_done) begin
                        ind_valid <= 1'b1;
                        ind_code  <= arb_won ? IND_GRANT : IND_DENY;
                        ind_type  <= RT_IMM;
                        ind_data  <= imm_data;
                        if (!new_imm) begin
                            state <= SQ_IDLE;
                        end
                    end
                end
                SQ_ASYNC: begin
                    if (new_imm) begin
                        state    <= SQ_IMM;
                        imm_data <= word_data;
                    end else if (arb_done) begin
                        state <= SQ_IDLE;
                        if (arb_won) begin
                            ind_valid <= 1'b1;
                            ind_code  <= IND_GRANT;
                            ind_type  <= pend_type;
                            ind_data  <= pend_data;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lreq_handler.sv
// Link request handler top: serial decode, pending slot and sequencer.
// Assumes all inputs are synchronous to clk.
module lreq_handler
    import lreq_pkg::*;
#(
    parameter int DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreq_in,
    input  logic              fair_gap,
    input  logic              arb_gap,
    input  logic              arb_done,
    input  logic              arb_won,
    output logic              arb_req,
    output logic              ind_valid,
    output logic [1:0]        ind_code,
    output logic [TYPE_W-1:0] ind_type,
    output logic [DATA_W-1:0] ind_data
);

    logic              dec_valid;
    logic [TYPE_W-1:0] dec_type;
    logic [DATA_W-1:0] dec_data;
    logic              pend_valid;
    logic [TYPE_W-1:0] pend_type;
    logic [DATA_W-1:0] pend_data;
    logic              serve;

    lreq_deser #(.TYPE_W(TYPE_W), .DATA_W(DATA_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_in     (lreq_in),
        .word_valid (dec_valid),
        .word_type  (dec_type),
        .word_data  (dec_data)
    );

    lreq_slot #(.DATA_W(DATA_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (dec_valid),
        .word_type  (dec_type),
        .word_data  (dec_data),
        .serve      (serve),
        .pend_valid (pend_valid),
        .pend_type  (pend_type),
        .pend_data  (pend_data)
    );

    lreq_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (dec_valid),
        .word_type  (dec_type),
        .word_data  (dec_data),
        .pend_valid (pend_valid),
        .pend_type  (pend_type),
        .pend_data  (pend_data),
        .fair_gap   (fair_gap),
        .arb_gap    (arb_gap),
        .arb_done   (arb_done),
        .arb_won    (arb_won),
        .serve      (serve),
        .arb_req    (arb_req),
        .ind_valid  (ind_valid),
        .ind_code   (ind_code),
        .ind_type   (ind_type),
        .ind_data   (ind_data)
    );

endmodule

// File: rtl/lreq_handler_chk.sv
// Protocol checker for lreq_handler, attached by bind.
// It tracks unanswered immediate requests on its own.
module lreq_handler_chk
    import lreq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [TYPE_W-1:0] dec_type,
    input logic              pend_valid,
    input logic              arb_req,
    input logic              ind_valid,
    input logic [1:0]        ind_code,
    input logic [TYPE_W-1:0] ind_type
);

    logic imm_wait;
    logic imm_seen;
    logic answered;

    assign imm_seen = dec_valid && (dec_type == RT_IMM);
    assign answered = ind_valid && (ind_code != IND_STATUS);

    // Track an immediate request until its grant or deny appears.
    always_ff @(posedge clk) begin
        if (!rst_n)        imm_wait <= 1'b0;
        else if (imm_seen) imm_wait <= 1'b1;
        else if (answered) imm_wait <= 1'b0;
    end

    // R9
    imm_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm_wait |-> !(ind_valid && ind_code == IND_STATUS));

    // R9
    imm_clears_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm_seen |=> !pend_valid);

    // R4
    status_with_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_valid && ind_code == IND_STATUS) |-> arb_req);

    // R8
    answer_after_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        answered |-> $past(arb_req));

    // R8
    deny_only_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_valid && ind_code == IND_DENY) |-> ind_type == RT_IMM);

    // R12
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind_valid |-> ind_code != IND_NONE);

endmodule

bind lreq_handler lreq_handler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_type   (dec_type),
    .pend_valid (pend_valid),
    .arb_req    (arb_req),
    .ind_valid  (ind_valid),
    .ind_code   (ind_code),
    .ind_type   (ind_type)
);

// File: tb/test_lreq_handler.sv
// Self-checking bench: directed scenarios plus seeded random traffic,
// compared each cycle against a reference built from the requirements.
module test_lreq_handler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser = 1'b0, fg = 1'b0, ag = 1'b0, ad = 1'b0, aw = 1'b0;
    logic       arb_req, ind_valid;
    logic [1:0] ind_code;
    logic [2:0] ind_type, ind_data;

    int         n_tests = 0;
    int         n_fail  = 0;
    string      tag     = "R1";

    always #2 clk = ~clk;

    lreq_handler i_lreq_handler (
        .clk(clk), .rst_n(rst_n), .lreq_in(ser), .fair_gap(fg),
        .arb_gap(ag), .arb_done(ad), .arb_won(aw), .arb_req(arb_req),
        .ind_valid(ind_valid), .ind_code(ind_code),
        .ind_type(ind_type), .ind_data(ind_data)
    );

    // Reference state
    logic       m_busy, m_rv, m_pv, e_iv;
    logic [2:0] m_cnt, m_rt, m_rd, m_pk, m_pd, m_imd, e_it, e_id;
    logic [5:0] m_sh;
    logic [1:0] m_st, e_ic;

    function automatic logic [1:0] ref_code(input logic won, input logic imm);
        if (!won) return 2'b11;
        return 2'b10;
    endfunction

    // Reference model, stepped on each rising edge.
    always @(posedge clk) begin
        logic [5:0] w;
        logic imm, asy;
        if (!rst_n) begin
            m_busy <= 0; m_cnt <= 0; m_sh <= 0; m_rv <= 0; m_rt <= 0; m_rd <= 0;
            m_st <= 0; m_pv <= 0; m_pk <= 0; m_pd <= 0; m_imd <= 0;
            e_iv <= 0; e_ic <= 0; e_it <= 0; e_id <= 0;
        end else begin
            w = {m_sh[4:0], ser};
            m_rv <= 0;
            if (m_busy) begin
                m_sh <= w;
                if (m_cnt == 5) begin
                    m_busy <= 0; m_cnt <= 0; m_rv <= 1;
                    m_rt <= w[5:3]; m_rd <= w[2:0];
                end else m_cnt <= m_cnt + 1;
            end else if (ser) begin
                m_busy <= 1; m_cnt <= 0;
            end
            imm = m_rv && m_rt == 3'd1;
            asy = m_rv && (m_rt == 3'd2 || m_rt == 3'd3);
            e_iv <= 0;
            case (m_st)
                2'd0: if (imm) begin m_st <= 1; m_imd <= m_rd; end
                      else if (m_pv && (fg || (m_pk == 3'd3 && ag))) begin
                          m_st <= 2; e_iv <= 1; e_ic <= 2'b01; e_it <= m_pk; e_id <= m_pd;
                      end
                2'd1: begin
                    if (imm) m_imd <= m_rd;
                    if (ad) begin
                        e_iv <= 1; e_ic <= ref_code(aw, 1'b1); e_it <= 3'd1; e_id <= m_imd;
                        if (!imm) m_st <= 0;
                    end
                end
                default: if (imm) begin m_st <= 1; m_imd <= m_rd; end
                      else if (ad) begin
                          m_st <= 0;
                          if (aw) begin e_iv <= 1; e_ic <= 2'b10; e_it <= m_pk; e_id <= m_pd; end
                      end
            endcase
            if (imm) m_pv <= 0;
            else if (asy) begin m_pv <= 1; m_pk <= m_rt; m_pd <= m_rd; end
            else if (m_st == 2 && ad && aw) m_pv <= 0;
        end
    end

    task automatic check(input string t, input logic ok, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // One cycle: compare outputs (away from the edge), then drive inputs.
    task automatic step(input logic s, input logic f, input logic a,
                        input logic d, input logic wn);
        @(negedge clk);
        check(tag, arb_req == (m_st != 0), "arb_req", arb_req, m_st != 0);
        check(tag, ind_valid == e_iv, "ind_valid", ind_valid, e_iv);
        if (e_iv && ind_valid)
            check(tag, {ind_code, ind_type, ind_data} == {e_ic, e_it, e_id},
                  "code/type/data", {ind_code, ind_type, ind_data}, {e_ic, e_it, e_id});
        ser = s; fg = f; ag = a; ad = d; aw = wn;
    endtask

    task automatic send(input logic [2:0] t, input logic [2:0] d);
        logic [6:0] fr;
        fr = {1'b1, t, d};
        for (int i = 6; i >= 0; i--) step(fr[i], 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] tx;
        int tx_n;
        void'($urandom(32'd1394));
        repeat (3) @(negedge clk);
        check("R1", !ind_valid && !arb_req, "reset outputs", {ind_valid, arb_req}, 0);
        rst_n = 1'b1;
        tag = "R1"; idle(3);
        // R2 R4 R6: fair request, arb_gap ignored, fair gap, win
        tag = "R4"; send(3'd2, 3'd5); step(0, 0, 1, 0, 0); idle(2);
        step(0, 1, 0, 0, 0); idle(2);
        tag = "R6"; step(0, 0, 0, 1, 1); idle(3);
        // R5 priority on arb_gap
        tag = "R5"; send(3'd3, 3'd6); step(0, 0, 1, 0, 0); idle(1); step(0, 0, 0, 1, 1); idle(2);
        // R7 lost then retry
        tag = "R7"; send(3'd2, 3'd1); step(0, 1, 0, 0, 0); idle(1); step(0, 0, 0, 1, 0); idle(2);
        step(0, 1, 0, 0, 0); step(0, 0, 0, 1, 1); idle(2);
        // R8 immediate won and lost
        tag = "R8"; send(3'd1, 3'd4); idle(1); step(0, 0, 0, 1, 1); idle(2);
        send(3'd1, 3'd2); step(0, 0, 0, 1, 0); idle(2);
        // R9 immediate cancels pending fair; later gap gives no status
        tag = "R9"; send(3'd2, 3'd7); send(3'd1, 3'd3); step(0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 1); step(0, 1, 0, 0, 0); idle(3);
        // R10 immediate during async arbitration, simultaneous done discarded
        tag = "R10"; send(3'd2, 3'd2); step(0, 1, 0, 0, 0);
        send(3'd1, 3'd6);
        idle(1); step(0, 0, 0, 1, 0); idle(2);
        // R11 replacement
        tag = "R11"; send(3'd2, 3'd1); send(3'd3, 3'd5); step(0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 1); idle(2);
        // R3 reserved codes
        tag = "R3"; send(3'd5, 3'd7); send(3'd0, 3'd1); step(0, 1, 1, 0, 0);
        step(0, 0, 0, 1, 1); idle(2);
        // R2 R12: random traffic
        tag = "R12"; tx = 0; tx_n = 0;
        for (int c = 0; c < 6000; c++) begin
            logic f, a, d, wn, s;
            if (tx_n == 0 && ($urandom % 6) == 0) begin
                int k = $urandom % 6;
                logic [2:0] t = (k < 2) ? 3'd1 : (k == 2) ? 3'd2 : (k == 3) ? 3'd3 : 3'(k + 2);
                tx = {1'b1, t, 3'($urandom)}; tx_n = 7;
            end
            s = 0;
            if (tx_n > 0) begin s = tx[6]; tx = tx << 1; tx_n--; end
            f = ($urandom % 12) == 0;
            a = ($urandom % 9) == 0;
            d = (m_st != 0) ? (($urandom % 4) == 0) : (($urandom % 25) == 0);
            wn = $urandom % 2;
            if (c == 3000) tag = "R2";
            step(s, f, a, d, wn);
        end
        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule